// File: doc/BRIEF.md
# Dual-Port Expander Register Front End

This block sits between a byte-oriented bus engine and the register banks of a dual 8-bit port expander. The bus engine hands it a stream of byte transactions: a pointer load that sets the internal register address, followed by any number of data writes or data reads. The block decodes the current pointer into a port (A or B) and a register index, strobes the matching port register bank, returns read bytes on a response stream, and then moves the pointer according to the configured addressing mode.

One shared configuration register lives inside the block. It selects between a paired address layout (A and B copies of each register interleaved) and a segregated layout (each port in its own 16-byte block). It also chooses whether the pointer advances after each data byte or stays put for polling, and it shapes the two interrupt pins: optional mirroring of both port interrupts onto both pins, output polarity, and push-pull or open-drain drive.

Both byte interfaces are valid/ready. A transaction is taken on a clock edge where `txn_valid` and `txn_ready` are both high. `txn_ready` is low whenever a read response is waiting, so at most one response is outstanding; a response is held unchanged on `rsp_data` until `rsp_ready` is seen high with `rsp_valid`. Port strobes and the port read data are combinational within the accepting cycle.

Top module: `xp_regfront`

## Requirements
- R1: After reset the configuration register reads 0x00, the pointer is 0x00, `rsp_valid` is low, `txn_ready` is high, and with no port interrupt both pins are driven (`int_*_oe`=1) high (inactive, active-low).
- R2: With the bank bit (config bit 7) clear, pointer values 0x00 to 0x15 map to port A when even and port B when odd, with register index equal to the pointer shifted right by one; a write pulses exactly one of the write strobes with `reg_wdata` equal to the byte, a read pulses exactly one read strobe and returns that port's `*_rdata`.
- R3: With the bank bit set, pointer bit 4 selects the port (0 = A, 1 = B) and bits 3:0 are the register index, mapped for index 0 to 10.
- R4: Register index 5 of either port is the single configuration register (paired: 0x0A and 0x0B; segregated: 0x05 and 0x15); accessing it raises no port strobe. Only bits 7 (bank), 6 (mirror), 5 (pointer hold), 2 (open-drain) and 1 (active-high) are stored; other bits read 0.
- R5: A pointer outside the current map (paired 0x16 to 0x1F, segregated index 11 to 15) reads 0x00, raises no strobe, and a write there changes nothing.
- R6: In paired mode with pointer hold clear, each data byte advances the pointer by one, and 0x15 wraps to 0x00.
- R7: In segregated mode with pointer hold clear, the pointer advances by one and wraps within its port block: 0x0A to 0x00 and 0x1A to 0x10.
- R8: With pointer hold set, the pointer does not change after a data byte.
- R9: The pointer step after a configuration write uses the settings in force before that write; the new bank setting decodes the next access.
- R10: With mirror clear each pin reflects only its own port interrupt; with mirror set both pins reflect the OR of the two port interrupts.
- R11: In push-pull mode (open-drain bit clear) the pin is always driven, high when active if the active-high bit is set, low when active otherwise.
- R12: With the open-drain bit set the pin value is always 0 and the enable is high exactly when the interrupt is active, whatever the active-high bit.
- R13: While `rsp_valid` is high, `txn_ready` is low and no transaction is taken; `rsp_data` stays unchanged until taken by `rsp_ready`.
- R14: A pointer load (`txn_kind` 0) sets the pointer from the low 5 bits of `txn_data` with no strobe and no step; `txn_kind` 1 is a data write, 2 a data read, 3 a no-operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| txn_valid | input | 1 | Transaction offered |
| txn_ready | output | 1 | Transaction can be taken |
| txn_kind | input | 2 | 0 pointer load, 1 write, 2 read, 3 no-op |
| txn_data | input | DATA_W | Pointer value or write byte |
| rsp_valid | output | 1 | Read byte waiting |
| rsp_ready | input | 1 | Consumer takes the read byte |
| rsp_data | output | DATA_W | Read byte |
| reg_idx | output | IDX_W | Register index within the selected port |
| reg_wdata | output | DATA_W | Byte for the port write strobe |
| a_wr_stb | output | 1 | Port A register write |
| a_rd_stb | output | 1 | Port A register read |
| b_wr_stb | output | 1 | Port B register write |
| b_rd_stb | output | 1 | Port B register read |
| a_rdata | input | DATA_W | Port A register contents at `reg_idx` |
| b_rdata | input | DATA_W | Port B register contents at `reg_idx` |
| a_irq | input | 1 | Port A interrupt, active high |
| b_irq | input | 1 | Port B interrupt, active high |
| int_a_o | output | 1 | Interrupt pin A value |
| int_a_oe | output | 1 | Interrupt pin A drive enable |
| int_b_o | output | 1 | Interrupt pin B value |
| int_b_oe | output | 1 | Interrupt pin B drive enable |

## Verification
The hardest situation to reach is a configuration write that flips the bank bit, because the step taken right after it must follow the old layout while the next decode follows the new one. The stimulus reaches it by parking the pointer on the configuration alias with hold set, writing a byte that sets bank and clears hold, and then reading: the read must land on the segregated decode of the unchanged pointer and then wrap inside the port block. The reverse switch is driven from the segregated alias at 0x05, where the step to 0x06 is then decoded as paired port A index 3.

// File: rtl/xp_regfront_pkg.sv
package xp_regfront_pkg;

  typedef enum logic [1:0] {
    TXN_PTR  = 2'd0,
    TXN_WR   = 2'd1,
    TXN_RD   = 2'd2,
    TXN_NOP  = 2'd3
  } txn_kind_e;

  // bit positions inside the configuration byte
  localparam int CFG_BANK_POS   = 7;
  localparam int CFG_MIRROR_POS = 6;
  localparam int CFG_HOLD_POS   = 5;
  localparam int CFG_OD_POS     = 2;
  localparam int CFG_HIGH_POS   = 1;

  typedef struct packed {
    logic bank;
    logic mirror;
    logic hold;
    logic odrain;
    logic act_high;
  } cfg_t;

endpackage

// File: rtl/xp_addr_map.sv
module xp_addr_map #(
  parameter int PORT_REGS = 11,
  parameter int CFG_IDX   = 5,
  parameter int IDX_W     = $clog2(PORT_REGS),
  parameter int PTR_W     = IDX_W + 1
) (
  input  logic [PTR_W-1:0] ptr,
  input  logic             bank,
  output logic             hit,
  output logic             port_b,
  output logic [IDX_W-1:0] idx,
  output logic             is_cfg
);
  localparam logic [PTR_W-1:0] PAIR_LAST = PTR_W'(2 * PORT_REGS - 1);
  localparam logic [IDX_W-1:0] SEG_LAST  = IDX_W'(PORT_REGS - 1);
  localparam logic [IDX_W-1:0] CFG_SLOT  = IDX_W'(CFG_IDX);

  always_comb begin
    if (bank) begin
      port_b = ptr[PTR_W-1];
      idx    = ptr[IDX_W-1:0];
      hit    = (ptr[IDX_W-1:0] <= SEG_LAST);
    end else begin
      port_b = ptr[0];
      idx    = ptr[PTR_W-1:1];
      hit    = (ptr <= PAIR_LAST);
    end
    is_cfg = hit && (idx == CFG_SLOT);
  end
endmodule

// File: rtl/xp_ptr_step.sv
module xp_ptr_step #(
  parameter int PORT_REGS = 11,
  parameter int IDX_W     = $clog2(PORT_REGS),
  parameter int PTR_W     = IDX_W + 1
) (
  input  logic [PTR_W-1:0] ptr,
  input  logic             bank,
  input  logic             hold,
  output logic [PTR_W-1:0] nxt
);
  localparam logic [PTR_W-1:0] PAIR_LAST = PTR_W'(2 * PORT_REGS - 1);
  localparam logic [IDX_W-1:0] SEG_LAST  = IDX_W'(PORT_REGS - 1);

  always_comb begin
    if (hold) begin
      nxt = ptr;
    end else if (!bank) begin
      nxt = (ptr == PAIR_LAST) ? '0 : ptr + 1'b1;
    end else if (ptr[IDX_W-1:0] == SEG_LAST) begin
      nxt = {ptr[PTR_W-1], {IDX_W{1'b0}}};
    end else begin
      nxt = ptr + 1'b1;
    end
  end
endmodule

// File: rtl/xp_irq_pin.sv
module xp_irq_pin (
  input  logic lvl,
  input  logic act_high,
  input  logic odrain,
  output logic pin_o,
  output logic pin_oe
);
  always_comb begin
    if (odrain) begin
      pin_o  = 1'b0;
      pin_oe = lvl;
    end else begin
      pin_oe = 1'b1;
      pin_o  = act_high ? lvl : ~lvl;
    end
  end
endmodule

// File: rtl/xp_regfront.sv
module xp_regfront
  import xp_regfront_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int PORT_REGS = 11,
  parameter int CFG_IDX   = 5,
  parameter int IDX_W     = $clog2(PORT_REGS),
  parameter int PTR_W     = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              txn_valid,
  output logic              txn_ready,
  input  logic [1:0]        txn_kind,
  input  logic [DATA_W-1:0] txn_data,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_data,
  output logic [IDX_W-1:0]  reg_idx,
  output logic [DATA_W-1:0] reg_wdata,
  output logic              a_wr_stb,
  output logic              a_rd_stb,
  output logic              b_wr_stb,
  output logic              b_rd_stb,
  input  logic [DATA_W-1:0] a_rdata,
  input  logic [DATA_W-1:0] b_rdata,
  input  logic              a_irq,
  input  logic              b_irq,
  output logic              int_a_o,
  output logic              int_a_oe,
  output logic              int_b_o,
  output logic              int_b_oe
);
  localparam int NPIN = 2;

  txn_kind_e        kind;
  cfg_t             cfg_q;
  logic [PTR_W-1:0] ptr_q;
  logic [PTR_W-1:0] ptr_nxt;
  logic             take, do_ptr, do_wr, do_rd;
  logic             hit, port_b, is_cfg, port_ok;
  logic [IDX_W-1:0] idx;
  logic [DATA_W-1:0] cfg_byte, rd_byte;
  logic             cfg_hold, cfg_od;

  assign kind      = txn_kind_e'(txn_kind);
  assign txn_ready = ~rsp_valid;
  assign take      = txn_valid & txn_ready;
  assign do_ptr    = take & (kind == TXN_PTR);
  assign do_wr     = take & (kind == TXN_WR);
  assign do_rd     = take & (kind == TXN_RD);
  assign cfg_hold  = cfg_q.hold;
  assign cfg_od    = cfg_q.odrain;

  xp_addr_map #(
    .PORT_REGS(PORT_REGS), .CFG_IDX(CFG_IDX), .IDX_W(IDX_W), .PTR_W(PTR_W)
  ) u_map (
    .ptr(ptr_q), .bank(cfg_q.bank), .hit(hit), .port_b(port_b),
    .idx(idx), .is_cfg(is_cfg)
  );

  xp_ptr_step #(
    .PORT_REGS(PORT_REGS), .IDX_W(IDX_W), .PTR_W(PTR_W)
  ) u_step (
    .ptr(ptr_q), .bank(cfg_q.bank), .hold(cfg_q.hold), .nxt(ptr_nxt)
  );

  // port strobes
  assign port_ok   = hit & ~is_cfg;
  assign reg_idx   = idx;
  assign reg_wdata = txn_data;
  assign a_wr_stb  = do_wr & port_ok & ~port_b;
  assign b_wr_stb  = do_wr & port_ok &  port_b;
  assign a_rd_stb  = do_rd & port_ok & ~port_b;
  assign b_rd_stb  = do_rd & port_ok &  port_b;

  // configuration byte image
  always_comb begin
    cfg_byte                 = '0;
    cfg_byte[CFG_BANK_POS]   = cfg_q.bank;
    cfg_byte[CFG_MIRROR_POS] = cfg_q.mirror;
    cfg_byte[CFG_HOLD_POS]   = cfg_q.hold;
    cfg_byte[CFG_OD_POS]     = cfg_q.odrain;
    cfg_byte[CFG_HIGH_POS]   = cfg_q.act_high;
  end

  always_comb begin
    if (!hit)        rd_byte = '0;
    else if (is_cfg) rd_byte = cfg_byte;
    else if (port_b) rd_byte = b_rdata;
    else             rd_byte = a_rdata;
  end

  // configuration register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (do_wr && is_cfg) begin
      cfg_q.bank     <= txn_data[CFG_BANK_POS];
      cfg_q.mirror   <= txn_data[CFG_MIRROR_POS];
      cfg_q.hold     <= txn_data[CFG_HOLD_POS];
      cfg_q.odrain   <= txn_data[CFG_OD_POS];
      cfg_q.act_high <= txn_data[CFG_HIGH_POS];
    end
  end

  // address pointer; the step uses the settings before this access
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              ptr_q <= '0;
    else if (do_ptr)         ptr_q <= txn_data[PTR_W-1:0];
    else if (do_wr || do_rd) ptr_q <= ptr_nxt;
  end

  // read response slot
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else if (do_rd) begin
      rsp_valid <= 1'b1;
      rsp_data  <= rd_byte;
    end else if (rsp_valid && rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  // interrupt pins
  logic [NPIN-1:0] src_irq, pin_lvl, pin_o, pin_oe;
  assign src_irq = {b_irq, a_irq};

  for (genvar g = 0; g < NPIN; g++) begin : g_pin
    assign pin_lvl[g] = src_irq[g] | (cfg_q.mirror & src_irq[NPIN-1-g]);
    xp_irq_pin u_pin (
      .lvl(pin_lvl[g]), .act_high(cfg_q.act_high), .odrain(cfg_q.odrain),
      .pin_o(pin_o[g]), .pin_oe(pin_oe[g])
    );
  end

  assign int_a_o  = pin_o[0];
  assign int_a_oe = pin_oe[0];
  assign int_b_o  = pin_o[1];
  assign int_b_oe = pin_oe[1];
endmodule

// File: rtl/xp_regfront_chk.sv
module xp_regfront_chk #(
  parameter int DATA_W  = 8,
  parameter int CFG_IDX = 5,
  parameter int IDX_W   = 4,
  parameter int PTR_W   = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              txn_valid,
  input logic              txn_ready,
  input logic [1:0]        txn_kind,
  input logic [DATA_W-1:0] txn_data,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [DATA_W-1:0] rsp_data,
  input logic [IDX_W-1:0]  reg_idx,
  input logic              a_wr_stb,
  input logic              a_rd_stb,
  input logic              b_wr_stb,
  input logic              b_rd_stb,
  input logic              int_a_o,
  input logic              int_b_o,
  input logic [PTR_W-1:0]  ptr_q,
  input logic              cfg_hold,
  input logic              cfg_od
);
  logic any_stb, data_take;
  assign any_stb   = a_wr_stb | a_rd_stb | b_wr_stb | b_rd_stb;
  assign data_take = txn_valid & txn_ready & (txn_kind == 2'd1 || txn_kind == 2'd2);

  a_r2_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({a_wr_stb, a_rd_stb, b_wr_stb, b_rd_stb}));

  a_r4_cfg_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    any_stb |-> (reg_idx != IDX_W'(CFG_IDX)));

  a_r8_hold_keeps_ptr: assert property (@(posedge clk) disable iff (!rst_n)
    (data_take && cfg_hold) |=> $stable(ptr_q));

  a_r12_od_never_high: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_od |-> (!int_a_o && !int_b_o));

  a_r13_no_take_busy: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !txn_ready);

  a_r13_rsp_held: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));

  a_r14_ptr_load: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_valid && txn_ready && txn_kind == 2'd0) |=> (ptr_q == $past(txn_data[PTR_W-1:0])));

  a_r14_load_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_valid && txn_ready && txn_kind == 2'd0) |-> !any_stb);
endmodule

bind xp_regfront xp_regfront_chk #(
  .DATA_W(DATA_W), .CFG_IDX(CFG_IDX), .IDX_W(IDX_W), .PTR_W(PTR_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .txn_valid(txn_valid), .txn_ready(txn_ready),
  .txn_kind(txn_kind), .txn_data(txn_data), .rsp_valid(rsp_valid),
  .rsp_ready(rsp_ready), .rsp_data(rsp_data), .reg_idx(reg_idx),
  .a_wr_stb(a_wr_stb), .a_rd_stb(a_rd_stb), .b_wr_stb(b_wr_stb),
  .b_rd_stb(b_rd_stb), .int_a_o(int_a_o), .int_b_o(int_b_o),
  .ptr_q(ptr_q), .cfg_hold(cfg_hold), .cfg_od(cfg_od)
);

// File: tb/xp_regfront_tb.sv
`timescale 1ns/1ps
module xp_regfront_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic       txn_valid = 1'b0, rsp_ready = 1'b1, a_irq = 1'b0, b_irq = 1'b0;
  logic [1:0] txn_kind = 2'd3;
  logic [7:0] txn_data = 8'h00;
  logic       txn_ready, rsp_valid;
  logic [7:0] rsp_data, reg_wdata, a_rdata, b_rdata;
  logic [3:0] reg_idx;
  logic       a_wr_stb, a_rd_stb, b_wr_stb, b_rd_stb;
  logic       int_a_o, int_a_oe, int_b_o, int_b_oe;

  // port register models: contents derived from the index
  assign a_rdata = 8'hA0 | {4'h0, reg_idx};
  assign b_rdata = 8'hB0 | {4'h0, reg_idx};

  xp_regfront u_dut (
    .clk(clk), .rst_n(rst_n), .txn_valid(txn_valid), .txn_ready(txn_ready),
    .txn_kind(txn_kind), .txn_data(txn_data), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_data(rsp_data), .reg_idx(reg_idx),
    .reg_wdata(reg_wdata), .a_wr_stb(a_wr_stb), .a_rd_stb(a_rd_stb),
    .b_wr_stb(b_wr_stb), .b_rd_stb(b_rd_stb), .a_rdata(a_rdata),
    .b_rdata(b_rdata), .a_irq(a_irq), .b_irq(b_irq), .int_a_o(int_a_o),
    .int_a_oe(int_a_oe), .int_b_o(int_b_o), .int_b_oe(int_b_oe)
  );

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  // {tag, kind, data, strobes {awr,ard,bwr,brd}, index, read byte}
  localparam int NV = 42;
  localparam logic [29:0] VEC [NV] = '{
    {4'd14, 2'd0, 8'h00, 4'h0, 4'h0, 8'h00},  // R14 load 0x00
    {4'd2,  2'd2, 8'h00, 4'h4, 4'h0, 8'hA0},  // R2 A idx0
    {4'd6,  2'd2, 8'h00, 4'h1, 4'h0, 8'hB0},  // R6 stepped to B idx0
    {4'd2,  2'd1, 8'h55, 4'h8, 4'h1, 8'h00},  // R2 A idx1 write
    {4'd14, 2'd0, 8'h13, 4'h0, 4'h0, 8'h00},
    {4'd2,  2'd2, 8'h00, 4'h1, 4'h9, 8'hB9},
    {4'd2,  2'd2, 8'h00, 4'h4, 4'hA, 8'hAA},
    {4'd6,  2'd2, 8'h00, 4'h1, 4'hA, 8'hBA},  // R6 at 0x15
    {4'd6,  2'd2, 8'h00, 4'h4, 4'h0, 8'hA0},  // R6 wrapped to 0x00
    {4'd14, 2'd0, 8'h0A, 4'h0, 4'h0, 8'h00},
    {4'd4,  2'd1, 8'h22, 4'h0, 4'h0, 8'h00},  // R4 cfg: hold + active high
    {4'd4,  2'd2, 8'h00, 4'h0, 4'h0, 8'h22},  // R4 alias at 0x0B
    {4'd8,  2'd2, 8'h00, 4'h0, 4'h0, 8'h22},  // R8 pointer held
    {4'd14, 2'd0, 8'h03, 4'h0, 4'h0, 8'h00},
    {4'd8,  2'd2, 8'h00, 4'h1, 4'h1, 8'hB1},
    {4'd8,  2'd2, 8'h00, 4'h1, 4'h1, 8'hB1},  // R8 same register again
    {4'd14, 2'd0, 8'h16, 4'h0, 4'h0, 8'h00},
    {4'd5,  2'd2, 8'h00, 4'h0, 4'h0, 8'h00},  // R5 unmapped read
    {4'd5,  2'd1, 8'hFF, 4'h0, 4'h0, 8'h00},  // R5 unmapped write
    {4'd14, 2'd0, 8'h0B, 4'h0, 4'h0, 8'h00},
    {4'd5,  2'd2, 8'h00, 4'h0, 4'h0, 8'h22},  // R5 cfg untouched
    {4'd14, 2'd0, 8'h0A, 4'h0, 4'h0, 8'h00},
    {4'd9,  2'd1, 8'h80, 4'h0, 4'h0, 8'h00},  // R9 bank on, old hold keeps 0x0A
    {4'd9,  2'd2, 8'h00, 4'h4, 4'hA, 8'hAA},  // R9 segregated A idx10
    {4'd7,  2'd2, 8'h00, 4'h4, 4'h0, 8'hA0},  // R7 wrapped 0x0A->0x00
    {4'd14, 2'd0, 8'h1A, 4'h0, 4'h0, 8'h00},
    {4'd3,  2'd2, 8'h00, 4'h1, 4'hA, 8'hBA},  // R3 B idx10
    {4'd7,  2'd2, 8'h00, 4'h1, 4'h0, 8'hB0},  // R7 wrapped 0x1A->0x10
    {4'd14, 2'd0, 8'h15, 4'h0, 4'h0, 8'h00},
    {4'd4,  2'd2, 8'h00, 4'h0, 4'h0, 8'h80},  // R4 segregated alias 0x15
    {4'd3,  2'd2, 8'h00, 4'h1, 4'h6, 8'hB6},  // R3 0x16 is B idx6
    {4'd14, 2'd0, 8'h0C, 4'h0, 4'h0, 8'h00},
    {4'd5,  2'd2, 8'h00, 4'h0, 4'h0, 8'h00},  // R5 segregated idx12
    {4'd14, 2'd0, 8'h05, 4'h0, 4'h0, 8'h00},
    {4'd9,  2'd1, 8'h00, 4'h0, 4'h0, 8'h00},  // R9 bank off, step to 0x06
    {4'd9,  2'd2, 8'h00, 4'h4, 4'h3, 8'hA3},  // R9 paired 0x06 A idx3
    {4'd14, 2'd0, 8'h0B, 4'h0, 4'h0, 8'h00},
    {4'd4,  2'd1, 8'h7F, 4'h0, 4'h0, 8'h00},  // R4 unused bits dropped
    {4'd14, 2'd0, 8'h0A, 4'h0, 4'h0, 8'h00},
    {4'd4,  2'd2, 8'h00, 4'h0, 4'h0, 8'h66},
    {4'd4,  2'd1, 8'h00, 4'h0, 4'h0, 8'h00},
    {4'd4,  2'd2, 8'h00, 4'h0, 4'h0, 8'h00}
  };

  // one transaction with rsp_ready high; strobes checked inside the taking cycle
  task automatic run_txn(input string tag, input logic [1:0] k, input logic [7:0] d,
                         input logic [3:0] es, input logic [3:0] ei, input logic [7:0] er);
    @(negedge clk);
    txn_valid = 1'b1; txn_kind = k; txn_data = d;
    #1;
    check({tag, " strobes"}, {28'h0, a_wr_stb, a_rd_stb, b_wr_stb, b_rd_stb}, {28'h0, es});
    if (es != 4'h0) check({tag, " index"}, {28'h0, reg_idx}, {28'h0, ei});
    if (es[3] || es[1]) check({tag, " wdata"}, {24'h0, reg_wdata}, {24'h0, d});
    @(negedge clk);
    txn_valid = 1'b0; txn_kind = 2'd3;
    if (k == 2'd2) begin
      check({tag, " rsp_valid"}, {31'h0, rsp_valid}, 32'h1);
      check({tag, " rsp_data"}, {24'h0, rsp_data}, {24'h0, er});
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    check("R1 rsp_valid", {31'h0, rsp_valid}, 32'h0);
    check("R1 txn_ready", {31'h0, txn_ready}, 32'h1);
    check("R1 pin A", {30'h0, int_a_o, int_a_oe}, 32'h3);
    check("R1 pin B", {30'h0, int_b_o, int_b_oe}, 32'h3);
    run_txn("R1 pointer zero", 2'd2, 8'h00, 4'h4, 4'h0, 8'hA0);
    run_txn("R1", 2'd0, 8'h0A, 4'h0, 4'h0, 8'h00);
    run_txn("R1 cfg zero", 2'd2, 8'h00, 4'h0, 4'h0, 8'h00);

    for (int i = 0; i < NV; i++) begin
      string t;
      t = $sformatf("R%0d vec%0d", VEC[i][29:26], i);
      run_txn(t, VEC[i][25:24], VEC[i][23:16], VEC[i][15:12], VEC[i][11:8], VEC[i][7:0]);
    end

    // interrupt pin shaping: R10 mirror, R11 push-pull polarity, R12 open drain
    for (int c = 0; c < 8; c++) begin
      logic m, od, hi;
      m = c[2]; od = c[1]; hi = c[0];
      run_txn("R4 cfg set", 2'd0, 8'h0A, 4'h0, 4'h0, 8'h00);
      run_txn("R4 cfg set", 2'd1, {1'b0, m, 3'b000, od, hi, 1'b0}, 4'h0, 4'h0, 8'h00);
      for (int s = 0; s < 4; s++) begin
        logic la, lb, ea_o, ea_oe, eb_o, eb_oe;
        string t;
        @(negedge clk);
        a_irq = s[0]; b_irq = s[1];
        #1;
        la = s[0] | (m & s[1]);
        lb = s[1] | (m & s[0]);
        if (od) begin
          ea_o = 1'b0; ea_oe = la; eb_o = 1'b0; eb_oe = lb; t = "R12";
        end else begin
          ea_oe = 1'b1; eb_oe = 1'b1;
          ea_o = hi ? la : ~la; eb_o = hi ? lb : ~lb;
          t = m ? "R10" : "R11";
        end
        check($sformatf("%s pinA cfg%0d irq%0d", t, c, s), {30'h0, int_a_o, int_a_oe}, {30'h0, ea_o, ea_oe});
        check($sformatf("%s pinB cfg%0d irq%0d", t, c, s), {30'h0, int_b_o, int_b_oe}, {30'h0, eb_o, eb_oe});
      end
      @(negedge clk);
      a_irq = 1'b0; b_irq = 1'b0;
    end
    run_txn("R4 cfg clear", 2'd0, 8'h0A, 4'h0, 4'h0, 8'h00);
    run_txn("R4 cfg clear", 2'd1, 8'h00, 4'h0, 4'h0, 8'h00);
    run_txn("R14", 2'd0, 8'h00, 4'h0, 4'h0, 8'h00);

    // R13 back-pressure on the response stream
    @(negedge clk);
    rsp_ready = 1'b0;
    txn_valid = 1'b1; txn_kind = 2'd2; txn_data = 8'h00;
    @(negedge clk);
    txn_kind = 2'd1; txn_data = 8'h3C;
    #1;
    check("R13 rsp_valid", {31'h0, rsp_valid}, 32'h1);
    check("R13 ready low", {31'h0, txn_ready}, 32'h0);
    check("R13 no strobe", {28'h0, a_wr_stb, a_rd_stb, b_wr_stb, b_rd_stb}, 32'h0);
    repeat (3) @(negedge clk);
    #1;
    check("R13 data held", {24'h0, rsp_data}, 32'hA0);
    check("R13 still busy", {30'h0, rsp_valid, txn_ready}, 32'h2);
    rsp_ready = 1'b1;
    @(negedge clk);
    #1;
    check("R13 released", {31'h0, txn_ready}, 32'h1);
    check("R13 held write lands at B idx0", {28'h0, a_wr_stb, a_rd_stb, b_wr_stb, b_rd_stb}, 32'h2);
    @(negedge clk);
    txn_valid = 1'b0; txn_kind = 2'd3;

    finish_run();
  end
endmodule